// File: doc/BRIEF.md
# Incremental Three-Coefficient PID Controller Datapath

This block is a discrete PID controller in velocity form. Each new control value equals the previous control value plus a weighted sum of the current input sample and the two samples before it: y[n] = y[n-1] + C0·x[n] + C1·x[n-1] + C2·x[n-2]. The three weights fold the proportional gain, integral time, derivative time and sampling period into constants. Software or a neighbouring block computes them and writes them in through a small select/data register port. The datapath never works with the gains themselves.

A sample arrives with a one-cycle valid strobe. The block forms the weighted sum and the new output in that cycle, then registers them. The new control value appears on the next cycle with its own one-cycle valid strobe. The running output saturates at the 26-bit signed limits instead of wrapping. A clear input empties the sample history and the running output but leaves the coefficients alone. This lets a supervisor reset the integrator, for example to limit windup, without reloading the coefficients.

Top module: `pid_velocity_core`

## Requirements
- R1: On a sample strobe, the next output is y_prev + C0·x + C1·x1 + C2·x2. All values are signed two's complement, and each product is sign-extended before the sum.
- R2: A sample strobe moves the history. The older slot x2 takes the value of x1, and x1 takes the new sample. No other input changes the history, except a clear or a reset.
- R3: out_valid is high for exactly the one cycle after an accepted sample strobe. In that cycle out_data carries the new value.
- R4: If the exact sum is above 2^25-1, out_data becomes 2^25-1 (0x1FFFFFF).
- R5: If the exact sum is below -2^25, out_data becomes -2^25 (0x2000000).
- R6: A synchronous active-high reset clears the output, out_valid, both history slots and all three coefficients to zero.
- R7: coef_we with coef_sel writes coef_wdata into C0, C1 or C2 for select codes 0, 1 or 2. Select code 3 is ignored. A write in the same cycle as a sample strobe does not affect that sample; the new value first applies to the next sample.
- R8: clr zeroes the output and both history slots and leaves the coefficients unchanged. When clr and a sample strobe arrive together, clr wins: the sample is dropped and out_valid stays low.
- R9: Between accepted samples, out_data holds its last value and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero the output and history, keep the coefficients |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 2 | Coefficient select: 0=C0, 1=C1, 2=C2, 3=none |
| coef_wdata | input | 12 | Signed coefficient value |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 10 | Signed input sample |
| out_valid | output | 1 | New control value strobe |
| out_data | output | 26 | Signed control value |

## Verification
An impulse test with distinct small coefficients checks the order of the history taps. A design that swapped the taps or failed to shift them would produce the wrong sequence of partial sums. Long runs of extreme samples and extreme coefficients drive the output into both limits. A design that wrapped would flip sign there, and a design that sign-extended the products wrongly would drift. Other cases cover a coefficient write in the same cycle as a sample, a write with select code 3, and clr together with a strobe. Errors there show up as a sample weighted by the new coefficient, a corrupted coefficient, or a spurious valid pulse after a clear.

// File: rtl/pid_pkg.sv
package pid_pkg;
  parameter int PID_SMP_W  = 10;
  parameter int PID_COEF_W = 12;
  parameter int PID_OUT_W  = 26;
  parameter int PID_TAPS   = 3;
endpackage

// File: rtl/pid_coef_bank.sv
module pid_coef_bank #(
  parameter int COEF_W = 12,
  parameter int TAPS   = 3,
  parameter int SEL_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SEL_W-1:0]         sel,
  input  logic [COEF_W-1:0]        wdata,
  output logic [TAPS*COEF_W-1:0]   coef_flat
);
  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_coef
      logic [COEF_W-1:0] c_q;
      always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else if (we && (sel == SEL_W'(k))) c_q <= wdata;
      end
      assign coef_flat[k*COEF_W +: COEF_W] = c_q;
    end
  endgenerate
endmodule

// File: rtl/pid_hist.sv
module pid_hist #(
  parameter int SMP_W = 10,
  parameter int TAPS  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        shift,
  input  logic [SMP_W-1:0]            x_in,
  output logic [(TAPS-1)*SMP_W-1:0]   hist_flat
);
  localparam int DEPTH = TAPS - 1;
  logic [SMP_W-1:0] stage [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst || clr) stage[k] <= '0;
        else if (shift) begin
          if (k == 0) stage[k] <= x_in;
          else        stage[k] <= stage[(k == 0) ? 0 : k-1];
        end
      end
      assign hist_flat[k*SMP_W +: SMP_W] = stage[k];
    end
  endgenerate
endmodule

// File: rtl/pid_mac.sv
module pid_mac #(
  parameter int SMP_W  = 10,
  parameter int COEF_W = 12,
  parameter int OUT_W  = 26,
  parameter int TAPS   = 3
) (
  input  logic [SMP_W-1:0]            x_in,
  input  logic [(TAPS-1)*SMP_W-1:0]   hist_flat,
  input  logic [TAPS*COEF_W-1:0]      coef_flat,
  input  logic [OUT_W-1:0]            y_prev,
  output logic [OUT_W-1:0]            y_next
);
  localparam int PROD_W = SMP_W + COEF_W;
  localparam int SUM_W  = OUT_W + $clog2(TAPS + 1) + 1;
  localparam logic [OUT_W-1:0] Y_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] Y_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [TAPS*SMP_W-1:0] taps_flat;
  logic [TAPS*SUM_W-1:0] prod_ext;

  assign taps_flat = {hist_flat, x_in};

  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_prod
      logic signed [PROD_W-1:0] p;
      assign p = $signed(taps_flat[k*SMP_W +: SMP_W]) *
                 $signed(coef_flat[k*COEF_W +: COEF_W]);
      assign prod_ext[k*SUM_W +: SUM_W] = {{(SUM_W-PROD_W){p[PROD_W-1]}}, p};
    end
  endgenerate

  logic [SUM_W-1:0] acc;
  logic             fits;

  always_comb begin
    acc = {{(SUM_W-OUT_W){y_prev[OUT_W-1]}}, y_prev};
    for (int i = 0; i < TAPS; i++) acc = acc + prod_ext[i*SUM_W +: SUM_W];
    fits = (acc[SUM_W-1:OUT_W-1] == '0) || (acc[SUM_W-1:OUT_W-1] == '1);
    if (fits)                y_next = acc[OUT_W-1:0];
    else if (acc[SUM_W-1])   y_next = Y_MIN;
    else                     y_next = Y_MAX;
  end
endmodule

// File: rtl/pid_velocity_core.sv
module pid_velocity_core #(
  parameter int SMP_W  = pid_pkg::PID_SMP_W,
  parameter int COEF_W = pid_pkg::PID_COEF_W,
  parameter int OUT_W  = pid_pkg::PID_OUT_W,
  parameter int TAPS   = pid_pkg::PID_TAPS,
  parameter int SEL_W  = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              coef_we,
  input  logic [SEL_W-1:0]  coef_sel,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data
);
  logic [TAPS*COEF_W-1:0]     coef_flat;
  logic [(TAPS-1)*SMP_W-1:0]  hist_flat;
  logic [OUT_W-1:0]           y_next;
  logic                       accept;

  assign accept = smp_valid && !clr;

  pid_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .SEL_W(SEL_W)) u_coef (
    .clk(clk), .rst(rst), .we(coef_we), .sel(coef_sel),
    .wdata(coef_wdata), .coef_flat(coef_flat)
  );

  pid_hist #(.SMP_W(SMP_W), .TAPS(TAPS)) u_hist (
    .clk(clk), .rst(rst), .clr(clr), .shift(accept),
    .x_in(smp_data), .hist_flat(hist_flat)
  );

  pid_mac #(.SMP_W(SMP_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .TAPS(TAPS)) u_mac (
    .x_in(smp_data), .hist_flat(hist_flat), .coef_flat(coef_flat),
    .y_prev(out_data), .y_next(y_next)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) out_data <= y_next;
    end
  end
endmodule

// File: rtl/pid_velocity_core_chk.sv
module pid_velocity_core_chk #(
  parameter int OUT_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             smp_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  // R3
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !clr) |=> out_valid);
  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_valid && !clr));
  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (out_data == '0 && !out_valid));
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !clr) |=> $stable(out_data));
  // R6
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (out_data == '0 && !out_valid));
endmodule

bind pid_velocity_core pid_velocity_core_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .smp_valid(smp_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_pid_velocity_core.sv
`timescale 1ns/1ps
module tb_pid_velocity_core;
  logic        clk = 1'b0;
  logic        rst, clr, coef_we, smp_valid;
  logic [1:0]  coef_sel;
  logic [11:0] coef_wdata;
  logic [9:0]  smp_data;
  logic        out_valid;
  logic [25:0] out_data;

  int checks = 0, failures = 0;
  string cur_req = "R6";
  bit finished = 0;

  always #5 clk = ~clk;

  pid_velocity_core dut (
    .clk(clk), .rst(rst), .clr(clr), .coef_we(coef_we), .coef_sel(coef_sel),
    .coef_wdata(coef_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // behavioural reference
  longint m_c[3];
  longint m_x1, m_x2, m_y;
  bit     m_v;
  localparam longint YMAX = (64'sd1 <<< 25) - 1;
  localparam longint YMIN = -(64'sd1 <<< 25);

  always @(posedge clk) begin
    if (rst) begin
      m_c[0] = 0; m_c[1] = 0; m_c[2] = 0;
      m_x1 = 0; m_x2 = 0; m_y = 0; m_v = 0;
    end else begin
      if (clr) begin
        m_x1 = 0; m_x2 = 0; m_y = 0; m_v = 0;
      end else if (smp_valid) begin
        longint xs, s;
        xs = longint'($signed(smp_data));
        s  = m_y + m_c[0]*xs + m_c[1]*m_x1 + m_c[2]*m_x2;
        if (s > YMAX) s = YMAX;
        if (s < YMIN) s = YMIN;
        m_y = s; m_x2 = m_x1; m_x1 = xs; m_v = 1;
      end else m_v = 0;
      if (coef_we && coef_sel != 2'd3)
        m_c[coef_sel] = longint'($signed(coef_wdata));
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst === 1'b0 || rst === 1'b1) begin
      longint got;
      got = longint'($signed(out_data));
      checks++;
      if (out_valid !== m_v || got != m_y) begin
        failures++;
        $display("FAIL %s: out_valid=%0b out_data=%0d expected valid=%0b data=%0d",
                 cur_req, out_valid, got, m_v, m_y);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      clr = 0; coef_we = 0; smp_valid = 0;
    end
  endtask

  task automatic wcoef(int sel, int val);
    @(negedge clk);
    smp_valid = 0; clr = 0;
    coef_we = 1; coef_sel = 2'(sel); coef_wdata = 12'(val);
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic sample(int val);
    @(negedge clk);
    clr = 0; coef_we = 0;
    smp_valid = 1; smp_data = 10'(val);
    @(negedge clk);
    smp_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; clr = 0; coef_we = 0; coef_sel = 0; coef_wdata = 0;
    smp_valid = 0; smp_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R6"; idle(2);

    // R2 impulse with distinct coefficients, selector code 3 ignored (R7)
    cur_req = "R7";
    wcoef(0, 1); wcoef(1, 10); wcoef(2, 100); wcoef(3, 2047);
    cur_req = "R2";
    sample(1); sample(0); sample(0); sample(0); idle(2);

    // R1 mixed signs
    cur_req = "R1";
    wcoef(0, -300); wcoef(1, 517); wcoef(2, -2048);
    sample(-512); sample(511); sample(-7); sample(33); sample(0);

    // R9 hold between samples
    cur_req = "R9"; idle(5);

    // R7 write concurrent with sample
    cur_req = "R7";
    @(negedge clk);
    smp_valid = 1; smp_data = 10'd100;
    coef_we = 1; coef_sel = 2'd0; coef_wdata = 12'd5;
    @(negedge clk); smp_valid = 0; coef_we = 0;
    sample(100); idle(1);

    // R8 clear, clear with strobe, coefficients kept
    cur_req = "R8";
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 1; smp_valid = 1; smp_data = 10'd77;
    @(negedge clk); clr = 0; smp_valid = 0;
    sample(3); sample(-4); idle(1);

    // R4 positive saturation
    cur_req = "R4";
    wcoef(0, 2047); wcoef(1, 2047); wcoef(2, 2047);
    for (int i = 0; i < 20; i++) sample(511);
    sample(511);
    // R5 negative saturation
    cur_req = "R5";
    for (int i = 0; i < 30; i++) sample(-512);
    idle(1);

    // R6 reset in mid-run clears coefficients too
    cur_req = "R6";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    sample(200); sample(-200); idle(1);

    // R1/R3 random mix
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      clr        = ($urandom_range(0, 40) == 0);
      coef_we    = ($urandom_range(0, 6) == 0);
      coef_sel   = 2'($urandom);
      coef_wdata = 12'($urandom);
      smp_valid  = ($urandom_range(0, 2) != 0);
      smp_data   = 10'($urandom);
    end
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule